// File: doc/BRIEF.md
# Byte-granular register write-lock unit

This block sits between a bus slave port and a bank of byte-wide protected registers. It keeps one lock bit for every protected byte and suppresses bus writes to any byte whose lock bit is set. Software reaches the protected bytes through two address windows: a direct window, and a mirror window that performs the same write and also locks every byte it actually writes. A third window holds the lock control registers, one byte each, and each one covers four protected bytes.

The bus side takes one request per cycle (byte-enables, supervisor flag, address, write data). The result appears on the registered outputs in the following cycle: filtered byte write strobes toward the register bank, read data, and a one-cycle error flag. The register bank itself lies outside the block. The block drives a word read address combinationally and gets the bank's read data back combinationally.

With the default of 64 protected bytes, the address map is as follows. The direct window is 0x00-0x3F. The mirror window is 0x40-0x7F. The lock control registers are at 0x80-0x8F, one byte per register, so lock register n sits at byte address 0x80+n, which is word n/4 and lane n%4. The addresses 0x90-0xFF are unmapped.

Top module: `byte_wlock_unit`

## Requirements
- R1: After reset every lock bit is 0, bus_err is 0, prot_we is 0, and a read of any lock register returns 0.
- R2: In lock register n, bits 7..4 are write-enable bits E0..E3 and bits 3..0 are lock bits L0..L3. L0 is bit 3 and L3 is bit 0. Lane j of a 32-bit word holds bits 8j+7..8j. The enable bits always read as 0.
- R3: On a supervisor write to lock register n, lock bit Lm takes the written value only when Em is 1 in the same byte. Otherwise Lm keeps its value.
- R4: Lock bit Lm of lock register n guards protected byte 4n+m. Protected byte b sits at word b/4, lane b%4 of the direct and mirror windows.
- R5: A direct-window write drives prot_we = byte-enables of unlocked lanes, prot_waddr = word index and prot_wdata = write data, all in the cycle after the request.
- R6: Lanes whose bytes are locked are left out of prot_we while the other lanes are still written. Any blocked lane raises bus_err.
- R7: A mirror-window write drives prot_we, prot_waddr and prot_wdata exactly as a direct write would. It also sets the lock bit of every lane it writes.
- R8: A mirror-window write to an already locked byte drops that lane, leaves its lock bit at 1 and raises bus_err.
- R9: A user-mode write (bus_sup=0) to a lock register changes no lock bit and raises bus_err. Reads of lock registers succeed in either mode.
- R10: Reads are never blocked. A direct or mirror read returns prot_rdata for the addressed word in the next cycle, including locked bytes, and a lock-window read returns the packed lock registers.
- R11: bus_err is high only in the cycle after a failing write. A write to an unmapped address changes nothing and raises no error, and a read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sup | input | 1 | 1 = supervisor mode |
| bus_addr | input | AW (8) | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle access-error flag |
| prot_raddr | output | WW (4) | Word read address to the register bank |
| prot_rdata | input | 32 | Read data from the register bank |
| prot_we | output | 4 | Filtered byte write strobes |
| prot_waddr | output | WW (4) | Word write address |
| prot_wdata | output | 32 | Write data to the register bank |

## Verification
The assertions assume that bus_addr is word aligned and that bus_req, bus_wr, bus_sup, bus_be and bus_wdata are steady around each rising edge. They also assume that prot_rdata follows prot_raddr within the same cycle. The bench meets these conditions by driving every input on the falling edge, keeping addresses aligned, and modelling the register bank as a byte array. The model answers reads combinationally and takes writes only from prot_we. Each scenario uses a fresh cycle per request, so no read or write overlaps a lock update made by the previous request.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        WIN_DIRECT = 2'd0,
        WIN_MIRROR = 2'd1,
        WIN_LOCK   = 2'd2,
        WIN_NONE   = 2'd3
    } win_e;
endpackage

// File: rtl/bwl_addr_decode.sv
module bwl_addr_decode
    import bwl_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    localparam int WIN_AW = $clog2(NUM_BYTES),
    localparam int AW     = WIN_AW + 2,
    localparam int WW     = WIN_AW - 2,
    localparam int LOCK_WORDS = NUM_BYTES / 16
) (
    input  logic [AW-1:0] addr,
    output win_e          win,
    output logic [WW-1:0] word
);
    logic [1:0] sel;

    always_comb begin
        sel  = addr[AW-1:AW-2];
        word = addr[WIN_AW-1:2];
        win  = win_e'(sel);
        // lock window holds only NUM_BYTES/4 byte registers
        if (win == WIN_LOCK && int'(word) >= LOCK_WORDS) begin
            win = WIN_NONE;
        end
    end
endmodule

// File: rtl/bwl_lane_guard.sv
module bwl_lane_guard
    import bwl_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    localparam int WIN_AW = $clog2(NUM_BYTES),
    localparam int WW     = WIN_AW - 2,
    localparam int LW     = WIN_AW - 4
) (
    input  logic [NUM_BYTES-1:0] lock,
    input  logic [WW-1:0]        word,
    output logic [LANES-1:0]     lane_lock,
    output logic [DATA_W-1:0]    lock_rd
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [1:0] JS = 2'(j);
        assign lane_lock[j] = lock[{word, JS}];
        for (genvar m = 0; m < 4; m++) begin : g_bit
            localparam logic [1:0] MS = 2'(m);
            // lock bit m sits at bit 3-m; enable bits read zero
            assign lock_rd[j*BYTE_W + 3 - m] = lock[{word[LW-1:0], JS, MS}];
            assign lock_rd[j*BYTE_W + 7 - m] = 1'b0;
        end
    end
endmodule

// File: rtl/bwl_lock_bank.sv
module bwl_lock_bank
    import bwl_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    localparam int WIN_AW = $clog2(NUM_BYTES),
    localparam int LW     = WIN_AW - 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] set_mask,
    input  logic                 ctl_we,
    input  logic [LW-1:0]        ctl_word,
    input  logic [LANES-1:0]     ctl_be,
    input  logic [DATA_W-1:0]    ctl_wdata,
    output logic [NUM_BYTES-1:0] lock_q
);
    logic [NUM_BYTES-1:0] lock_d;

    always_comb begin
        lock_d = lock_q | set_mask;
        if (ctl_we) begin
            for (int j = 0; j < LANES; j++) begin
                for (int m = 0; m < 4; m++) begin
                    if (ctl_be[j] && ctl_wdata[j*BYTE_W + 7 - m]) begin
                        lock_d[{ctl_word, 2'(j), 2'(m)}] = ctl_wdata[j*BYTE_W + 3 - m];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    AST_LOCK_CLEAR_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        ((~lock_q & $past(lock_q)) != '0) |-> $past(ctl_we)); // R3
    AST_MIRROR_SETS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((lock_q & $past(set_mask)) == $past(set_mask))); // R7
    AST_LOCK_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_q & ~$past(lock_q)) != '0) |-> $past(ctl_we || (set_mask != '0))); // R9
endmodule

// File: rtl/byte_wlock_unit.sv
module byte_wlock_unit
    import bwl_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    localparam int WIN_AW = $clog2(NUM_BYTES),
    localparam int AW     = WIN_AW + 2,
    localparam int WW     = WIN_AW - 2,
    localparam int LW     = WIN_AW - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic              bus_sup,
    input  logic [AW-1:0]     bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [WW-1:0]     prot_raddr,
    input  logic [31:0]       prot_rdata,
    output logic [3:0]        prot_we,
    output logic [WW-1:0]     prot_waddr,
    output logic [31:0]       prot_wdata
);
    typedef struct packed {
        logic [LANES-1:0]  we;
        logic [WW-1:0]     waddr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              lockrd;
    } st_t;

    st_t st_d, st_q;

    win_e                 win;
    logic [WW-1:0]        word;
    logic [NUM_BYTES-1:0] lock_q;
    logic [NUM_BYTES-1:0] set_mask;
    logic [LANES-1:0]     lane_lock;
    logic [LANES-1:0]     lane_ok;
    logic [DATA_W-1:0]    lock_rd;
    logic                 is_wr, is_rd, prot_win, ctl_we;

    bwl_addr_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
        .addr (bus_addr),
        .win  (win),
        .word (word)
    );

    bwl_lane_guard #(.NUM_BYTES(NUM_BYTES)) u_guard (
        .lock      (lock_q),
        .word      (word),
        .lane_lock (lane_lock),
        .lock_rd   (lock_rd)
    );

    bwl_lock_bank #(.NUM_BYTES(NUM_BYTES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_mask  (set_mask),
        .ctl_we    (ctl_we),
        .ctl_word  (word[LW-1:0]),
        .ctl_be    (bus_be),
        .ctl_wdata (bus_wdata),
        .lock_q    (lock_q)
    );

    assign prot_raddr = word;

    always_comb begin
        is_wr    = bus_req && bus_wr;
        is_rd    = bus_req && !bus_wr;
        prot_win = (win == WIN_DIRECT) || (win == WIN_MIRROR);
        lane_ok  = bus_be & ~lane_lock;
        ctl_we   = is_wr && (win == WIN_LOCK) && bus_sup;

        set_mask = '0;
        if (is_wr && win == WIN_MIRROR) begin
            for (int j = 0; j < LANES; j++) begin
                if (lane_ok[j]) set_mask[{word, 2'(j)}] = 1'b1;
            end
        end

        st_d        = st_q;
        st_d.we     = (is_wr && prot_win) ? lane_ok : '0;
        st_d.waddr  = is_wr ? word : st_q.waddr;
        st_d.wdata  = is_wr ? bus_wdata : st_q.wdata;
        st_d.rdata  = '0;
        if (is_rd) begin
            if (prot_win)              st_d.rdata = prot_rdata;
            else if (win == WIN_LOCK)  st_d.rdata = lock_rd;
        end
        st_d.err    = is_wr && ((prot_win && ((bus_be & lane_lock) != '0))
                                || (win == WIN_LOCK && !bus_sup));
        st_d.lockrd = is_rd && (win == WIN_LOCK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prot_we    = st_q.we;
    assign prot_waddr = st_q.waddr;
    assign prot_wdata = st_q.wdata;
    assign bus_rdata  = st_q.rdata;
    assign bus_err    = st_q.err;

    AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_we != '0) |-> $past(bus_req && bus_wr)); // R5
    AST_WE_SKIPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_we != '0) |-> (($past(lane_lock) & prot_we) == '0)); // R6
    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req && bus_wr)); // R11
    AST_LOCK_RD_ENABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lockrd |-> ((bus_rdata & 32'hF0F0_F0F0) == '0)); // R2
    AST_USER_NO_LOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && !bus_sup && win == WIN_LOCK) |=> bus_err); // R9
endmodule

// File: tb/sim_byte_wlock_unit.sv
module sim_byte_wlock_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0, bus_sup = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  prot_raddr, prot_waddr;
    logic [31:0] prot_rdata, prot_wdata;
    logic [3:0]  prot_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] mem [64];
    logic [31:0] r_rdata, r_wdata;
    logic [3:0]  r_we, r_waddr;
    logic        r_err;

    always #2 clk = ~clk;

    byte_wlock_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_sup(bus_sup), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .prot_raddr(prot_raddr), .prot_rdata(prot_rdata), .prot_we(prot_we),
        .prot_waddr(prot_waddr), .prot_wdata(prot_wdata)
    );

    // register bank model
    assign prot_rdata = {mem[{prot_raddr, 2'd3}], mem[{prot_raddr, 2'd2}],
                         mem[{prot_raddr, 2'd1}], mem[{prot_raddr, 2'd0}]};
    always @(posedge clk) begin
        for (int j = 0; j < 4; j++)
            if (prot_we[j]) mem[{prot_waddr, 2'(j)}] <= prot_wdata[8*j +: 8];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                          input logic [3:0] be, input logic sup);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = addr;
        bus_wdata = data; bus_be = be; bus_sup = sup;
        @(negedge clk);
        r_rdata = bus_rdata; r_err = bus_err; r_we = prot_we;
        r_waddr = prot_waddr; r_wdata = prot_wdata;
        bus_req = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic t_reset;
        chk("R1 prot_we", {28'd0, prot_we}, 32'd0);
        chk("R1 bus_err", {31'd0, bus_err}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            access(1'b0, 8'h80 + 8'(4*k), '0, '0, 1'b1);
            chk("R1 lock word", r_rdata, 32'd0);
        end
    endtask

    task automatic t_direct;
        access(1'b1, 8'h04, 32'hA1B2_C3D4, 4'hF, 1'b0);
        chk("R5 we", {28'd0, r_we}, 32'hF);
        chk("R5 waddr", {28'd0, r_waddr}, 32'd1);
        chk("R5 wdata", r_wdata, 32'hA1B2_C3D4);
        chk("R5 err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h04, '0, '0, 1'b0);
        chk("R10 read", r_rdata, 32'hA1B2_C3D4);
    endtask

    task automatic t_lock_and_filter;
        // lock reg 1 = lane1 of word 0x80; E0..E3=1, L1=L3=1
        access(1'b1, 8'h80, 32'h0000_F500, 4'b0010, 1'b1);
        chk("R3 ctl err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h80, '0, '0, 1'b1);
        chk("R2 lock read", r_rdata, 32'h0000_0500);
        // bytes 5 and 7 locked
        access(1'b1, 8'h04, 32'h1122_3344, 4'hF, 1'b0);
        chk("R4 R6 filtered we", {28'd0, r_we}, 32'b0101);
        chk("R6 err", {31'd0, r_err}, 32'd1);
        @(negedge clk);
        chk("R11 err one cycle", {31'd0, bus_err}, 32'd0);
        access(1'b0, 8'h04, '0, '0, 1'b0);
        chk("R10 read locked", r_rdata, 32'hA122_C344);
    endtask

    task automatic t_enable_gating;
        // E2,E3 only, all lock bits 0: clears L2,L3; L1 stays
        access(1'b1, 8'h80, 32'h0000_3000, 4'b0010, 1'b1);
        access(1'b0, 8'h80, '0, '0, 1'b0);
        chk("R3 enable gating", r_rdata, 32'h0000_0400);
    endtask

    task automatic t_user_ctl;
        access(1'b1, 8'h80, 32'hFFFF_FFFF, 4'hF, 1'b0);
        chk("R9 user err", {31'd0, r_err}, 32'd1);
        access(1'b0, 8'h80, '0, '0, 1'b0);
        chk("R9 unchanged", r_rdata, 32'h0000_0400);
    endtask

    task automatic t_mirror;
        access(1'b1, 8'h48, 32'hDEAD_BEEF, 4'b0011, 1'b0);
        chk("R7 we", {28'd0, r_we}, 32'b0011);
        chk("R7 waddr", {28'd0, r_waddr}, 32'd2);
        chk("R7 wdata", r_wdata, 32'hDEAD_BEEF);
        chk("R7 err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h80, '0, '0, 1'b0);
        chk("R7 locks set", r_rdata, 32'h000C_0400);
        access(1'b1, 8'h48, 32'h0000_0000, 4'b0111, 1'b0);
        chk("R8 we", {28'd0, r_we}, 32'b0100);
        chk("R8 err", {31'd0, r_err}, 32'd1);
        access(1'b0, 8'h80, '0, '0, 1'b0);
        chk("R8 locks", r_rdata, 32'h000E_0400);
        access(1'b0, 8'h08, '0, '0, 1'b0);
        chk("R8 data kept", r_rdata, 32'h0000_BEEF);
    endtask

    task automatic t_unmapped;
        access(1'b1, 8'hC0, 32'hFFFF_FFFF, 4'hF, 1'b1);
        chk("R11 unmapped we", {28'd0, r_we}, 32'd0);
        chk("R11 unmapped err", {31'd0, r_err}, 32'd0);
        access(1'b1, 8'h90, 32'hFFFF_FFFF, 4'hF, 1'b1);
        chk("R11 gap err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'hC0, '0, '0, 1'b1);
        chk("R11 unmapped read", r_rdata, 32'd0);
        access(1'b0, 8'h80, '0, '0, 1'b0);
        chk("R11 locks intact", r_rdata, 32'h000E_0400);
    endtask

    task automatic t_high_reg;
        // lock reg 15 = lane3 of word 0x8C; E0=1, L0=1 -> byte 60
        access(1'b1, 8'h8C, 32'h8800_0000, 4'b1000, 1'b1);
        access(1'b0, 8'h8C, '0, '0, 1'b0);
        chk("R2 R4 high reg", r_rdata, 32'h0800_0000);
        access(1'b1, 8'h3C, 32'h5555_5555, 4'hF, 1'b0);
        chk("R4 byte 60 blocked", {28'd0, r_we}, 32'b1110);
        chk("R6 err high", {31'd0, r_err}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_lock_and_filter();
        t_enable_gating();
        t_user_ctl();
        t_mirror();
        t_unmapped();
        t_high_reg();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule